// File: doc/BRIEF.md
# Three-Wire Serial Bus Slave Receiver

This block receives write transfers on a three-line serial bus made of a clock, a data line and a framing enable line. A transfer opens when the enable line falls while the clock is high. It closes when the enable line rises while the clock is high. Between those two events, bytes arrive most significant bit first, and each byte is followed by a ninth clock for acknowledge.

The first byte carries a device address, and one bit of that address comes from a strap pin. When the address matches, the block pulls the data line low through an open-drain enable during every ninth clock. It also presents each following byte on a one-cycle valid strobe. If the enable input is wired to the data line, the same logic behaves as an ordinary I2C write-only slave.

All bus inputs are sampled through two-flop synchronisers on a system clock that runs at least sixteen times the bit rate. Bus events are then taken from edges of the synchronised copies.

Top module: `sbus_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_oe_o` and `rx_valid_o` are low.
- R2: A transfer begins on a falling edge of `sen_i` while `scl_i` is high, and ends on a rising edge of `sen_i` while `scl_i` is high. With `sen_i` held high, edges on `sda_i` while `scl_i` is high neither begin nor end a transfer.
- R3: With `sen_i` wired to the data line, the standard I2C start (data falls, clock high) and stop (data rises, clock high) frame transfers correctly.
- R4: Bits are sampled on the rising edge of `scl_i`, eight per byte, MSB first. The address byte that matches is {1,0,0,0,1,0,A,0} from MSB to LSB, where A is `addr_sel_i`: 8'h88 for A=0 and 8'h8A for A=1.
- R5: After a matching address byte, `sda_oe_o` is high during the whole high phase of the ninth clock.
- R6: Each data byte after a matched address raises `rx_valid_o` for exactly one system clock, with `rx_data_o` holding the byte. The byte is also acknowledged with `sda_oe_o` high during its ninth clock.
- R7: If the address byte does not match, including a byte whose LSB is 1, then no acknowledge is driven and no data byte is strobed until the next start.
- R8: A start in the middle of a transfer releases `sda_oe_o` and restarts address reception.
- R9: A stop in the middle of a byte discards the partial byte: no strobe follows. `sda_oe_o` is low after any stop.
- R10: `sda_oe_o` is an open-drain enable: it is high only to pull the line low, and it changes only while the synchronised clock is low, except when a start or stop forces it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sen_i | input | 1 | Bus framing enable line; tie to the data line for I2C |
| addr_sel_i | input | 1 | Strap that sets address bit 1 |
| sda_oe_o | output | 1 | Open-drain enable; high pulls the data line low |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new data byte |

## Verification
The hardest case to reach from the ports is a data edge during the clock-high phase while the enable line stays high. In I2C wiring that same edge is a legitimate start or stop, so it only shows up as a distinct case when the bench runs in three-wire mode. The bench sends a byte in three-wire mode whose first bit carries a low pulse on the data line inside the clock-high window. The byte must then arrive intact, which shows the pulse was not taken as framing. Stop-inside-a-byte and repeated start are produced by cutting a byte off after a few bit clocks. The bench then checks that the scoreboard queue receives nothing for the cut-off byte and that the next transfer is handled normally.

// File: rtl/sbus_rx_pkg.sv
package sbus_rx_pkg;

    localparam int BYTE_W   = 8;
    localparam int SYNC_LEN = 2;

    // upper six address bits; bit 1 comes from the strap, bit 0 is write
    localparam logic [5:0] DEV_ADDR_HI = 6'b100010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic sen;
        logic addr;
    } bus_lines_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_events_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic strap);
        return b == {DEV_ADDR_HI, strap, 1'b0};
    endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sbus_cond_det.sv
module sbus_cond_det
    import sbus_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_s,
    input  logic        sen_s,
    output bus_events_t ev
);
    logic scl_q, sen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sen_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sen_q <= sen_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_q & sen_q & ~sen_s;
        ev.stop     = scl_s & scl_q & ~sen_q & sen_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
    end
endmodule

// File: rtl/sbus_rx_fsm.sv
module sbus_rx_fsm
    import sbus_rx_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_events_t   ev,
    input  logic          sda_s,
    input  logic          strap_s,
    output logic          sda_oe,
    output logic [DW-1:0] data,
    output logic          valid
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

    rx_state_e        state;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
            data    <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (ev.stop) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_DATA: begin
                        if (ev.scl_rise && bit_cnt < FULL) begin
                            shreg   <= {shreg[DW-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.scl_fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, strap_s)) begin
                                    state  <= ST_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                state  <= ST_DATA_ACK;
                                sda_oe <= 1'b1;
                                data   <= shreg;
                                valid  <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sbus_rx.sv
module sbus_rx
    import sbus_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              sen_i,
    input  logic              addr_sel_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    bus_lines_t  lines_raw, lines_s;
    bus_events_t ev;
    logic        scl_s, start_det, stop_det;

    always_comb begin
        lines_raw.scl  = scl_i;
        lines_raw.sda  = sda_i;
        lines_raw.sen  = sen_i;
        lines_raw.addr = addr_sel_i;
    end

    sbus_sync #(.W($bits(bus_lines_t)), .STAGES(SYNC_LEN)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (lines_raw),
        .q   (lines_s)
    );

    sbus_cond_det det_i (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s.scl),
        .sen_s (lines_s.sen),
        .ev    (ev)
    );

    sbus_rx_fsm #(.DW(BYTE_W)) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .sda_s   (lines_s.sda),
        .strap_s (lines_s.addr),
        .sda_oe  (sda_oe_o),
        .data    (rx_data_o),
        .valid   (rx_valid_o)
    );

    assign scl_s     = lines_s.scl;
    assign start_det = ev.start;
    assign stop_det  = ev.stop;
endmodule

// File: rtl/sbus_rx_chk.sv
module sbus_rx_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe_o,
    input logic rx_valid_o
);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R6
    valid_acked_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> sda_oe_o);

    // R10
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_s);

    // R10
    oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_o) |-> (!scl_s || $past(start_det) || $past(stop_det)));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!sda_oe_o && !rx_valid_o));

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (!sda_oe_o && !rx_valid_o));
endmodule

bind sbus_rx sbus_rx_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_oe_o   (sda_oe_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/sbus_rx_tb_top.sv
module sbus_rx_tb_top;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sen_drv = 1'b1;
    logic       addr_sel = 1'b0;
    logic       i2c_mode = 1'b1;
    logic       sda_oe;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       sda_line, sen_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;
    assign sen_line = i2c_mode ? sda_line : sen_drv;

    sbus_rx dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sen_i      (sen_line),
        .addr_sel_i (addr_sel),
        .sda_oe_o   (sda_oe),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", rx_data, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rx_data == e, t, rx_data, e);
            end
        end
    end

    task automatic bus_start();
        scl = 1'b0; wq();
        sda_drv = 1'b1; sen_drv = 1'b1; wq();
        scl = 1'b1; wq();
        if (i2c_mode) sda_drv = 1'b0; else sen_drv = 1'b0;
        wq();
        scl = 1'b0; wq();
        sen_drv = 1'b1; wq();
    endtask

    task automatic bus_stop();
        scl = 1'b0; wq();
        if (i2c_mode) sda_drv = 1'b0; else begin sen_drv = 1'b0; sda_drv = 1'b1; end
        wq();
        scl = 1'b1; wq();
        if (i2c_mode) sda_drv = 1'b1; else sen_drv = 1'b1;
        wq();
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_drv = b; wq();
        scl = 1'b1; wq();
        if (glitch) begin
            sda_drv = 1'b0; repeat (Q/2) @(negedge clk);
            sda_drv = 1'b1; repeat (Q/2) @(negedge clk);
        end
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit push,
                             input string req, input bit glitch = 1'b0);
        if (push) begin
            exp_q.push_back(b);
            tag_q.push_back(req);
        end
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 7);
        sda_drv = 1'b1; wq();
        scl = 1'b1; repeat (Q/2) @(negedge clk);
        check(sda_oe == exp_ack, {req, " ack"}, sda_oe, exp_ack);
        repeat (Q/2) @(negedge clk);
        scl = 1'b0; wq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1
        check(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
        check(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(sda_oe == 1'b0 && rx_valid == 1'b0, "R1 after reset", sda_oe, 0);
        wq();

        // R3 R4 R5 R6: I2C wiring, strap low, address 8'h88
        i2c_mode = 1'b1; addr_sel = 1'b0; wq();
        bus_start();
        send_byte(8'h88, 1'b1, 1'b0, "R5 addr A=0");
        send_byte(8'hA5, 1'b1, 1'b1, "R6 byte A5");
        send_byte(8'h3C, 1'b1, 1'b1, "R3 byte 3C");
        bus_stop();
        check(sda_oe == 1'b0, "R9 oe after stop", sda_oe, 0);

        // R2 R4: three-wire framing, strap high, address 8'h8A
        i2c_mode = 1'b0; addr_sel = 1'b1; wq();
        bus_start();
        send_byte(8'h8A, 1'b1, 1'b0, "R4 addr A=1");
        send_byte(8'h01, 1'b1, 1'b1, "R2 byte 01");
        send_byte(8'hFF, 1'b1, 1'b1, "R2 byte FF");
        // R2: data pulse during clock high with enable high is not framing
        send_byte(8'hC3, 1'b1, 1'b1, "R2 data edge ignored", 1'b1);
        bus_stop();

        // R7: strap high but address for strap low
        bus_start();
        send_byte(8'h88, 1'b0, 1'b0, "R7 wrong strap");
        send_byte(8'h77, 1'b0, 1'b0, "R7 data skipped");
        bus_stop();

        // R7: read bit set
        i2c_mode = 1'b1; wq();
        bus_start();
        send_byte(8'h8B, 1'b0, 1'b0, "R7 read bit");
        send_byte(8'h12, 1'b0, 1'b0, "R7 data after read");
        bus_stop();

        // R9: stop inside a byte
        bus_start();
        send_byte(8'h8A, 1'b1, 1'b0, "R9 addr");
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        bus_stop();
        check(exp_q.size() == 0, "R9 no partial strobe", exp_q.size(), 0);
        bus_start();
        send_byte(8'h8A, 1'b1, 1'b0, "R9 addr again");
        send_byte(8'h5A, 1'b1, 1'b1, "R9 byte after cut");
        bus_stop();

        // R8: repeated start inside a byte, then new address
        bus_start();
        send_byte(8'h8A, 1'b1, 1'b0, "R8 addr");
        send_byte(8'h55, 1'b1, 1'b1, "R8 byte 55");
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
        bus_start();
        send_byte(8'h8A, 1'b1, 1'b0, "R8 addr restart");
        send_byte(8'h66, 1'b1, 1'b1, "R8 byte 66");
        bus_stop();

        wq();
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule